// File: doc/BRIEF.md
# PC-Relative Address and Load Decoder

This unit belongs to the execute side of a 64-bit RISC core. It takes one instruction word and its program counter, decodes the PC-relative opcode group and returns exactly one registered result. That result is a register write with an index and a value, a memory load request, or a reserved-instruction exception. The group contains four kinds of operation: add a scaled immediate to the PC, add an upper immediate to the PC, add an upper immediate to the PC and then clear the low 16 bits, and load a word or a doubleword from a PC-relative address.

The sub-opcode has three widths. A 2-bit field in bits 20:19 is tested first. When that field is 3, a 5-bit field in bits 20:16 and then a 3-bit field in bits 20:18 are tested. For the doubleword load, two of the immediate bits lie inside the wider selector. Each operation scales and aligns its own offset.

Instructions enter on a valid/ready stream. Load requests leave on a second valid/ready stream. A load request stays valid, with all of its fields unchanged, until the consumer raises `ld_ready`. While a load is pending and not being accepted, `in_ready` is low, so no new instruction enters. The write and exception outputs are single-cycle pulses that cannot be back-pressured. The `mode64` pin is a plain control input.

Top module: `pcrel_unit`

## Requirements
- R1: An instruction is in the group only when bits 31:26 equal 0x3B. An accepted instruction with any other value in those bits produces an exception pulse.
- R2: When bits 20:19 equal 0, the unit writes `pc + sext(bits18:0) * 4` to the register named by bits 25:21.
- R3: When bits 20:19 equal 1, the unit issues a word load (`ld_dword`=0, `ld_signed`=1) at `pc + sext(bits18:0) * 4`. When they equal 2 and `mode64`=1, it issues the same load with `ld_signed`=0.
- R4: When bits 20:16 equal 0x1E, the unit writes `pc + sext(bits15:0) * 65536`.
- R5: When bits 20:16 equal 0x1F, the unit writes the R4 sum with bits 15:0 cleared.
- R6: When bits 20:18 equal 6 and `mode64`=1, the unit issues a doubleword load (`ld_dword`=1, `ld_signed`=0). Its address is `(pc with bits 2:0 cleared) + sext(bits17:0) * 8`, and bits 17:16 count as immediate bits.
- R7: Inside the group, the following raise an exception pulse: bits 20:16 equal to 0x1C or 0x1D, and the unsigned word load or the doubleword load while `mode64`=0.
- R8: A non-load operation whose destination (bits 25:21) is 0 produces no write and no exception.
- R9: A load request holds `ld_valid`, `ld_addr`, `ld_dest`, `ld_dword` and `ld_signed` steady until `ld_ready` is sampled high. During that time `in_ready` is low.
- R10: After reset, all result valids are low and `in_ready` is high. Each accepted instruction produces its single result in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode64 | input | 1 | 1 enables the 64-bit-only loads |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can take an instruction |
| in_instr | input | 32 | Instruction word |
| in_pc | input | XLEN | Program counter of the instruction |
| wr_valid | output | 1 | Register write pulse |
| wr_idx | output | 5 | Destination register of the write |
| wr_data | output | XLEN | Value to write |
| ld_valid | output | 1 | Load request valid |
| ld_ready | input | 1 | Load consumer accepts |
| ld_addr | output | XLEN | Load address |
| ld_dword | output | 1 | 1 = doubleword load, 0 = word load |
| ld_signed | output | 1 | 1 = sign-extend the loaded word |
| ld_dest | output | 5 | Destination register for the loaded value |
| exc_valid | output | 1 | Reserved-instruction exception pulse |

## Verification
The hardest case to reach is a load request that is held back while a new instruction is already waiting at the input. The load fields must stay frozen, and the waiting instruction must enter only on the cycle the stall ends. The bench holds `ld_ready` low for several cycles with a second instruction presented. It then releases `ld_ready` and checks that the load drains and the waiting instruction's write appears one cycle later. The overlap of selector and immediate bits is reached by sweeping all 32 values of bits 20:16 against boundary immediates, unaligned PCs and both modes.

// File: rtl/pcrel_pkg.sv
package pcrel_pkg;
  typedef enum logic [2:0] {
    OP_ADDPC,
    OP_LWS,
    OP_LWU,
    OP_AUPC,
    OP_ALUPC,
    OP_LD,
    OP_RSVD
  } pcrel_op_e;

  localparam int REG_W = 5;
  localparam logic [5:0] PCREL_MAJOR = 6'h3B;
endpackage

// File: rtl/pcrel_decode.sv
module pcrel_decode
  import pcrel_pkg::*;
#(
  parameter logic [5:0] MAJOR = PCREL_MAJOR
) (
  input  logic [15:0]      instr_hi,
  input  logic             mode64,
  output pcrel_op_e        op,
  output logic [REG_W-1:0] rd
);
  logic [5:0] major;
  logic [4:0] sel5;
  logic [1:0] sel2;
  logic [2:0] sel3;

  assign major = instr_hi[15:10];
  assign rd    = instr_hi[9:5];
  assign sel5  = instr_hi[4:0];
  assign sel2  = sel5[4:3];
  assign sel3  = sel5[4:2];

  // narrow selector wins; value 3 falls through to the wide selectors
  always_comb begin
    op = OP_RSVD;
    if (major == MAJOR) begin
      case (sel2)
        2'd0: op = OP_ADDPC;
        2'd1: op = OP_LWS;
        2'd2: op = mode64 ? OP_LWU : OP_RSVD;
        default: begin
          if (sel5 == 5'h1E)                  op = OP_AUPC;
          else if (sel5 == 5'h1F)             op = OP_ALUPC;
          else if (sel3 == 3'b110 && mode64)  op = OP_LD;
          else                                op = OP_RSVD;
        end
      endcase
    end
  end
endmodule

// File: rtl/pcrel_addr.sv
module pcrel_addr
  import pcrel_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  pcrel_op_e        op,
  input  logic [18:0]      imm,
  input  logic [XLEN-1:0]  pc,
  output logic [XLEN-1:0]  value
);
  localparam int EXT19 = XLEN - 21;
  localparam int EXT16 = XLEN - 32;
  localparam int EXT18 = XLEN - 21;

  logic [XLEN-1:0] off_word;
  logic [XLEN-1:0] off_upper;
  logic [XLEN-1:0] off_dword;
  logic [XLEN-1:0] pc_dalign;
  logic [XLEN-1:0] upper_sum;

  assign off_word  = {{EXT19{imm[18]}}, imm[18:0], 2'b00};
  assign off_upper = {{EXT16{imm[15]}}, imm[15:0], 16'h0000};
  assign off_dword = {{EXT18{imm[17]}}, imm[17:0], 3'b000};
  assign pc_dalign = {pc[XLEN-1:3], 3'b000};
  assign upper_sum = pc + off_upper;

  always_comb begin
    case (op)
      OP_ADDPC, OP_LWS, OP_LWU: value = pc + off_word;
      OP_AUPC:                  value = upper_sum;
      OP_ALUPC:                 value = {upper_sum[XLEN-1:16], 16'h0000};
      OP_LD:                    value = pc_dalign + off_dword;
      default:                  value = '0;
    endcase
  end
endmodule

// File: rtl/pcrel_unit.sv
module pcrel_unit
  import pcrel_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode64,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_instr,
  input  logic [XLEN-1:0]  in_pc,
  output logic             wr_valid,
  output logic [4:0]       wr_idx,
  output logic [XLEN-1:0]  wr_data,
  output logic             ld_valid,
  input  logic             ld_ready,
  output logic [XLEN-1:0]  ld_addr,
  output logic             ld_dword,
  output logic             ld_signed,
  output logic [4:0]       ld_dest,
  output logic             exc_valid
);
  pcrel_op_e        op;
  logic [REG_W-1:0] rd;
  logic [XLEN-1:0]  value;
  logic             accept;
  logic             is_load;

  pcrel_decode #(.MAJOR(PCREL_MAJOR)) u_dec (
    .instr_hi (in_instr[31:16]),
    .mode64   (mode64),
    .op       (op),
    .rd       (rd)
  );

  pcrel_addr #(.XLEN(XLEN)) u_addr (
    .op    (op),
    .imm   (in_instr[18:0]),
    .pc    (in_pc),
    .value (value)
  );

  assign in_ready = rst_n && (!ld_valid || ld_ready);
  assign accept   = in_valid && in_ready;
  assign is_load  = (op == OP_LWS) || (op == OP_LWU) || (op == OP_LD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid  <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
      ld_valid  <= 1'b0;
      ld_addr   <= '0;
      ld_dword  <= 1'b0;
      ld_signed <= 1'b0;
      ld_dest   <= '0;
      exc_valid <= 1'b0;
    end else begin
      wr_valid  <= 1'b0;
      exc_valid <= 1'b0;
      if (ld_valid && ld_ready) ld_valid <= 1'b0;
      if (accept) begin
        if (op == OP_RSVD) begin
          exc_valid <= 1'b1;
        end else if (is_load) begin
          ld_valid  <= 1'b1;
          ld_addr   <= value;
          ld_dword  <= (op == OP_LD);
          ld_signed <= (op == OP_LWS);
          ld_dest   <= rd;
        end else if (rd != '0) begin
          wr_valid  <= 1'b1;
          wr_idx    <= rd;
          wr_data   <= value;
        end
      end
    end
  end

  AST_FOREIGN_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_instr[31:26] != PCREL_MAJOR) |=> exc_valid); // R1
  AST_LD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_dword) |-> (ld_addr[2:0] == 3'b000)); // R6
  AST_WR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_idx != '0)); // R8
  AST_LD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_ready) |=> (ld_valid && $stable(ld_addr) && $stable(ld_dest)
                                 && $stable(ld_dword) && $stable(ld_signed))); // R9
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_ready) |-> !in_ready); // R9
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_valid, ld_valid, exc_valid})); // R10
endmodule

// File: tb/tb_pcrel_unit.sv
module tb_pcrel_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode64 = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic [63:0] in_pc = '0;
  logic        wr_valid;
  logic [4:0]  wr_idx;
  logic [63:0] wr_data;
  logic        ld_valid;
  logic        ld_ready = 1'b1;
  logic [63:0] ld_addr;
  logic        ld_dword;
  logic        ld_signed;
  logic [4:0]  ld_dest;
  logic        exc_valid;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pcrel_unit #(.XLEN(64)) dut (
    .clk(clk), .rst_n(rst_n), .mode64(mode64),
    .in_valid(in_valid), .in_ready(in_ready), .in_instr(in_instr), .in_pc(in_pc),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .ld_dword(ld_dword), .ld_signed(ld_signed), .ld_dest(ld_dest),
    .exc_valid(exc_valid)
  );

  task automatic summary_and_end();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
      summary_and_end();
    end
  end

  task automatic check(input string req, input logic [139:0] got, input logic [139:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // result tuple: {wr,ld,exc, idx/dest, value/addr, dword, signed} padded
  function automatic logic [139:0] pack(input logic w, input logic l, input logic e,
                                        input logic [4:0] r, input logic [63:0] v,
                                        input logic d, input logic s);
    return {63'd0, w, l, e, r, v, d, s};
  endfunction

  function automatic logic [139:0] actual_tuple();
    if (wr_valid) return pack(wr_valid, ld_valid, exc_valid, wr_idx, wr_data, 1'b0, 1'b0);
    if (ld_valid) return pack(wr_valid, ld_valid, exc_valid, ld_dest, ld_addr, ld_dword, ld_signed);
    return pack(wr_valid, ld_valid, exc_valid, 5'd0, 64'd0, 1'b0, 1'b0);
  endfunction

  task automatic model(input logic [31:0] ins, input logic [63:0] pc, input logic m64,
                       output logic [139:0] exp, output string req);
    longint s19, s16, s18, base;
    logic [63:0] v;
    logic [4:0] rd;
    logic [4:0] s5;
    rd = ins[25:21];
    s5 = ins[20:16];
    s19 = longint'(ins[18:0]);  if (ins[18]) s19 = s19 - 524288;
    s16 = longint'(ins[15:0]);  if (ins[15]) s16 = s16 - 65536;
    s18 = longint'(ins[17:0]);  if (ins[17]) s18 = s18 - 262144;
    exp = pack(1'b0, 1'b0, 1'b1, 5'd0, 64'd0, 1'b0, 1'b0);
    if (ins[31:26] != 6'h3B) begin
      req = "R1";
    end else if (s5 / 8 == 0) begin
      req = "R2"; v = pc + 64'(s19 * 4);
      exp = (rd == 0) ? pack(0, 0, 0, 0, 0, 0, 0) : pack(1, 0, 0, rd, v, 0, 0);
      if (rd == 0) req = "R8";
    end else if (s5 / 8 == 1) begin
      req = "R3"; v = pc + 64'(s19 * 4);
      exp = pack(0, 1, 0, rd, v, 0, 1);
    end else if (s5 / 8 == 2) begin
      req = m64 ? "R3" : "R7"; v = pc + 64'(s19 * 4);
      if (m64) exp = pack(0, 1, 0, rd, v, 0, 0);
    end else if (s5 == 30 || s5 == 31) begin
      req = (s5 == 30) ? "R4" : "R5";
      v = pc + 64'(s16 * 65536);
      if (s5 == 31) v = v - (v % 65536);
      exp = (rd == 0) ? pack(0, 0, 0, 0, 0, 0, 0) : pack(1, 0, 0, rd, v, 0, 0);
      if (rd == 0) req = "R8";
    end else if (s5 >= 24 && s5 <= 27) begin
      req = m64 ? "R6" : "R7";
      base = longint'(pc) - longint'(pc % 8);
      v = 64'(base) + 64'(s18 * 8);
      if (m64) exp = pack(0, 1, 0, rd, v, 1, 0);
    end else begin
      req = "R7";
    end
  endtask

  task automatic issue(input logic [31:0] ins, input logic [63:0] pc, input logic m64);
    logic [139:0] exp;
    string req;
    model(ins, pc, m64, exp, req);
    @(negedge clk);
    in_valid = 1'b1; in_instr = ins; in_pc = pc; mode64 = m64;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " result"}, actual_tuple(), exp);
  endtask

  initial begin
    logic [15:0] imms [5] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hA5C3};
    logic [63:0] pcs [3] = '{64'h0000_0000_0040_1004, 64'hFFFF_FFFF_FFFF_FFF7,
                             64'h7FFF_FFFF_FFFF_0003};
    logic [4:0]  rds [3] = '{5'd0, 5'd31, 5'd7};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 reset", {136'd0, in_ready, wr_valid, ld_valid, exc_valid}, {136'd0, 4'b1000});

    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 32; s++)
        for (int i = 0; i < 5; i++)
          for (int p = 0; p < 3; p++)
            for (int r = 0; r < 3; r++)
              issue({6'h3B, rds[r], 5'(s), imms[i]}, pcs[p], 1'(m));

    // R1 foreign major opcodes
    for (int mj = 0; mj < 64; mj++)
      if (mj != 'h3B) issue({6'(mj), 5'd3, 5'd0, 16'h1234}, 64'h1000, 1'b1);

    // R9 back-pressure with a waiting instruction
    @(negedge clk);
    ld_ready = 1'b0;
    in_valid = 1'b1; in_instr = {6'h3B, 5'd9, 5'b01000, 16'h0010}; in_pc = 64'h2000; mode64 = 1'b1;
    @(negedge clk);
    in_instr = {6'h3B, 5'd4, 5'b00000, 16'h0003}; in_pc = 64'h3000;
    for (int k = 0; k < 3; k++) begin
      check("R9 held load", {in_ready, actual_tuple()[138:0]},
            {1'b0, pack(0, 1, 0, 5'd9, 64'h2040, 0, 1)[138:0]});
      @(negedge clk);
    end
    ld_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 waiting write after stall", actual_tuple(), pack(1, 0, 0, 5'd4, 64'h300C, 0, 0));
    @(negedge clk);
    check("R9 idle after drain", {136'd0, in_ready, wr_valid, ld_valid, exc_valid}, {136'd0, 4'b1000});

    summary_and_end();
  end
endmodule